// File: doc/BRIEF.md
# USB Peripheral Mode and Power Control

This block sits beside a USB peripheral controller core. It keeps one 16-bit mode register and turns three command bits into timed actions. Each command bit must be written to 1 and then back to 0 to take effect. The three actions are a soft reset, entry into suspend, and an upstream resume signal for remote wakeup. The block also gates the core clock and the DMA clock, mirrors the VBUS pin in the register, and passes the interrupt line out only when the global enable is set.

All timing is counted from a one-cycle millisecond tick input, `ms_tick_i`, and not from the system clock. A testbench can therefore drive the tick quickly. The block runs on an always-on clock. `core_clk_en_o` is the gate for the peripheral core clock. After a stop, that gate is reopened by a register read when the wake-on-read bit is set.

Top module: `usb_mode_ctrl`

## Requirements
- R1: After reset these outputs are low: `rdata_o` bits other than bit 8, `dma_clk_en_o`, `resume_o`, `suspended_o`, `soft_rst_o` and `int_o`. After reset `core_clk_en_o` is high.
- R2: The writable fields read back through `rdata_o` after the write cycle: DMA clock on at bit 9, clock always on at bit 7, send resume at bit 6, go suspend at bit 5, soft reset at bit 4, global interrupt enable at bit 3 and wake on read at bit 2. Bits 15:10 and 1:0 always read 0. Bit 8 shows `vbus_i`, delayed by two clock stages, and ignores writes.
- R3: A command fires only when a write puts 0 into a command bit whose stored value is 1. Writing 1 again to a bit that already holds 1 starts nothing.
- R4: After a resume command, `resume_o` rises in the cycle after the 5th millisecond tick. It falls in the cycle after the 10th tick that follows.
- R5: A resume command that arrives while a resume sequence is running is ignored. The sequence already running keeps its timing.
- R6: After a suspend command, `suspended_o` is high in the next cycle. With clock always on at 0, `core_clk_en_o` falls in the cycle after the 2nd tick.
- R7: With clock always on at 1, `core_clk_en_o` stays high for the whole suspend, however many ticks pass.
- R8: While suspended, a read (`rd_en_i`) with wake on read set clears `suspended_o` and raises `core_clk_en_o` in the next cycle. A read with wake on read clear leaves both unchanged.
- R9: A soft reset command raises `soft_rst_o` for exactly one cycle. In that same cycle the register reads 0 (bit 8 aside), `resume_o` and `suspended_o` are low, and any resume or suspend timer in progress is abandoned.
- R10: `dma_clk_en_o` equals the stored DMA clock on bit.
- R11: `int_o` is registered and follows global enable ANDed with the interrupt source, one cycle later. In level mode the source is `irq_level_i`, so a pending level appears one cycle after the enable is stored. In pulse mode the source is `irq_event_i`, and events that occur while the enable is 0 are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data |
| rd_en_i | input | 1 | Valid register read strobe |
| rdata_o | output | 16 | Mode register contents |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| vbus_i | input | 1 | VBUS pin level |
| irq_pulse_mode_i | input | 1 | 1 selects pulse interrupt mode |
| irq_level_i | input | 1 | Pending unmasked interrupt, level |
| irq_event_i | input | 1 | Unmasked interrupt event, one cycle |
| int_o | output | 1 | Gated interrupt output |
| resume_o | output | 1 | Upstream resume signalling |
| suspended_o | output | 1 | Controller is in suspend |
| core_clk_en_o | output | 1 | Core clock gate enable |
| dma_clk_en_o | output | 1 | DMA clock gate enable |
| soft_rst_o | output | 1 | Software reset request pulse |

## Verification
The bench targets five cases that are easy to get wrong:
- **Repeated writes of 1.** Writing 1 twice before the clearing 0 must not start anything. A design that fired on the 1 would raise `resume_o` before the 0 is written.
- **Tick counting.** The bench counts ticks one by one at both ends of the resume window and at the suspend stop point. An off-by-one counter moves an edge one tick early or late.
- **Resume restarted mid-delay.** A second resume command is issued during the delay. A design that restarted on it would raise `resume_o` late.
- **Soft reset while timers run.** A design that leaves a timer running after soft reset would still show `resume_o` or `suspended_o`.
- **Interrupt gating.** A pulse event while the enable is 0 must be lost. A pending level must appear one cycle after the enable is stored.

// File: rtl/usb_mode_pkg.sv
package usb_mode_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned B_DMA_CLK  = 9;
  localparam int unsigned B_VBUS     = 8;
  localparam int unsigned B_CLK_AON  = 7;
  localparam int unsigned B_RESUME   = 6;
  localparam int unsigned B_SUSPEND  = 5;
  localparam int unsigned B_SOFT_RST = 4;
  localparam int unsigned B_GIE      = 3;
  localparam int unsigned B_WAKE_RD  = 2;

  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << B_DMA_CLK) | (REG_W'(1) << B_CLK_AON) | (REG_W'(1) << B_RESUME) |
    (REG_W'(1) << B_SUSPEND) | (REG_W'(1) << B_SOFT_RST) | (REG_W'(1) << B_GIE) |
    (REG_W'(1) << B_WAKE_RD);

  typedef enum logic [1:0] {RS_IDLE, RS_WAIT, RS_DRIVE} rsm_state_e;
  typedef enum logic [1:0] {SP_AWAKE, SP_WAIT, SP_STOPPED} susp_state_e;
endpackage

// File: rtl/umc_mode_reg.sv
module umc_mode_reg
  import usb_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mode_o,
  output logic             fire_resume_o,
  output logic             fire_susp_o,
  output logic             fire_srst_o
);
  logic [REG_W-1:0] mode_q;

  // command fires on a 0 written over a stored 1
  assign fire_resume_o = wr_en_i & ~wdata_i[B_RESUME]   & mode_q[B_RESUME];
  assign fire_susp_o   = wr_en_i & ~wdata_i[B_SUSPEND]  & mode_q[B_SUSPEND];
  assign fire_srst_o   = wr_en_i & ~wdata_i[B_SOFT_RST] & mode_q[B_SOFT_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= '0;
    else if (fire_srst_o) mode_q <= '0;
    else if (wr_en_i)     mode_q <= wdata_i & WR_MASK;
  end

  assign mode_o = mode_q;

  p_cmd_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q[B_RESUME]) |-> $past(wr_en_i));
  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q & ~WR_MASK) == '0);
endmodule

// File: rtl/umc_resume_timer.sv
module umc_resume_timer
  import usb_mode_pkg::*;
#(
  parameter int unsigned DELAY_MS = 5,
  parameter int unsigned LEN_MS   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic tick_i,
  output logic resume_o,
  output logic busy_o
);
  localparam int unsigned MAXV  = (DELAY_MS > LEN_MS) ? DELAY_MS : LEN_MS;
  localparam int unsigned CNT_W = $clog2(MAXV + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_MS - 1);
  localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(LEN_MS - 1);

  rsm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else if (abort_i) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RS_IDLE: if (start_i) begin
          state_q <= RS_WAIT;
          cnt_q   <= '0;
        end
        RS_WAIT: if (tick_i) begin
          if (cnt_q == DLY_LAST) begin
            state_q <= RS_DRIVE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RS_DRIVE: if (tick_i) begin
          if (cnt_q == LEN_LAST) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign resume_o = (state_q == RS_DRIVE);
  assign busy_o   = (state_q != RS_IDLE);

  p_resume_rise_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_o) |-> $past(tick_i));
  p_resume_fall_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resume_o) |-> ($past(tick_i) || $past(abort_i)));
  p_no_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_o && start_i && !abort_i && !tick_i) |=> resume_o);
endmodule

// File: rtl/umc_suspend_ctl.sv
module umc_suspend_ctl
  import usb_mode_pkg::*;
#(
  parameter int unsigned STOP_MS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic tick_i,
  input  logic clk_aon_i,
  input  logic wake_rd_i,
  input  logic rd_i,
  output logic suspended_o,
  output logic clk_en_o
);
  localparam int unsigned CNT_W = $clog2(STOP_MS + 1);
  localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_MS - 1);

  susp_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wake;

  assign wake = rd_i & wake_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SP_AWAKE;
      cnt_q   <= '0;
    end else if (abort_i) begin
      state_q <= SP_AWAKE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SP_AWAKE: if (start_i) begin
          state_q <= SP_WAIT;
          cnt_q   <= '0;
        end
        SP_WAIT: begin
          if (wake) state_q <= SP_AWAKE;
          else if (tick_i && !clk_aon_i) begin
            if (cnt_q == STOP_LAST) state_q <= SP_STOPPED;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        SP_STOPPED: if (wake) state_q <= SP_AWAKE;
        default: state_q <= SP_AWAKE;
      endcase
    end
  end

  assign suspended_o = (state_q != SP_AWAKE);
  assign clk_en_o    = (state_q != SP_STOPPED);

  p_stop_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> ($past(tick_i) && !$past(clk_aon_i)));
  p_aon_keeps_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && clk_aon_i) |=> clk_en_o);
  p_wake_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && wake && !abort_i) |=> (!suspended_o && clk_en_o));
endmodule

// File: rtl/usb_mode_ctrl.sv
module usb_mode_ctrl
  import usb_mode_pkg::*;
#(
  parameter int unsigned RESUME_DELAY_MS = 5,
  parameter int unsigned RESUME_LEN_MS   = 10,
  parameter int unsigned SUSP_STOP_MS    = 2,
  parameter int unsigned VBUS_SYNC       = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wdata_i,
  input  logic        rd_en_i,
  output logic [15:0] rdata_o,
  input  logic        ms_tick_i,
  input  logic        vbus_i,
  input  logic        irq_pulse_mode_i,
  input  logic        irq_level_i,
  input  logic        irq_event_i,
  output logic        int_o,
  output logic        resume_o,
  output logic        suspended_o,
  output logic        core_clk_en_o,
  output logic        dma_clk_en_o,
  output logic        soft_rst_o
);
  logic [REG_W-1:0]     mode;
  logic                 fire_resume, fire_susp, fire_srst;
  logic                 resume_busy;
  logic [VBUS_SYNC-1:0] vbus_sync_q;
  logic                 srst_q, int_q;

  umc_mode_reg i_mode_reg (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i,
    .mode_o        (mode),
    .fire_resume_o (fire_resume),
    .fire_susp_o   (fire_susp),
    .fire_srst_o   (fire_srst)
  );

  umc_resume_timer #(.DELAY_MS(RESUME_DELAY_MS), .LEN_MS(RESUME_LEN_MS)) i_resume (
    .clk_i, .rst_ni,
    .start_i  (fire_resume),
    .abort_i  (fire_srst),
    .tick_i   (ms_tick_i),
    .resume_o (resume_o),
    .busy_o   (resume_busy)
  );

  umc_suspend_ctl #(.STOP_MS(SUSP_STOP_MS)) i_susp (
    .clk_i, .rst_ni,
    .start_i     (fire_susp),
    .abort_i     (fire_srst),
    .tick_i      (ms_tick_i),
    .clk_aon_i   (mode[B_CLK_AON]),
    .wake_rd_i   (mode[B_WAKE_RD]),
    .rd_i        (rd_en_i),
    .suspended_o (suspended_o),
    .clk_en_o    (core_clk_en_o)
  );

  generate
    for (genvar s = 0; s < VBUS_SYNC; s++) begin : g_vsync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vbus_sync_q[s] <= 1'b0;
        else if (s == 0) vbus_sync_q[s] <= vbus_i;
        else vbus_sync_q[s] <= vbus_sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      srst_q <= fire_srst;
      int_q  <= mode[B_GIE] & (irq_pulse_mode_i ? irq_event_i : irq_level_i);
    end
  end

  always_comb begin
    rdata_o         = mode;
    rdata_o[B_VBUS] = vbus_sync_q[VBUS_SYNC-1];
  end

  assign dma_clk_en_o = mode[B_DMA_CLK];
  assign soft_rst_o   = srst_q;
  assign int_o        = int_q;

  p_srst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (!resume_o && !suspended_o && (mode == '0)));
  p_srst_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  p_int_needs_gie_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> $past(mode[B_GIE]));
  p_busy_covers_resume_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> resume_busy);
endmodule

// File: tb/test_usb_mode_ctrl.sv
module test_usb_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, vbus = 1'b0;
  logic        pmode = 1'b0, ilvl = 1'b0, ievt = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        int_o, resume, susp, clk_en, dma_en, srst;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  usb_mode_ctrl i_usb_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .ms_tick_i(tick), .vbus_i(vbus), .irq_pulse_mode_i(pmode),
    .irq_level_i(ilvl), .irq_event_i(ievt), .int_o(int_o), .resume_o(resume),
    .suspended_o(susp), .core_clk_en_o(clk_en), .dma_clk_en_o(dma_en), .soft_rst_o(srst)
  );

  function automatic logic [15:0] exp_read(logic [15:0] v, logic vb);
    return (v & 16'h02FC & ~16'h0100) | {7'b0, vb, 8'b0};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic wr(logic [15:0] v);
    wr_en = 1'b1; wdata = v; step(); wr_en = 1'b0;
  endtask
  task automatic rd();
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask
  task automatic tk();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1761));
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 outs", {int_o, resume, susp, clk_en, dma_en, srst}, 6'b000100);

    // R2 / R10 random readback
    for (int i = 0; i < 40; i++) begin
      logic [15:0] v = 16'($urandom()) & ~16'h0070;
      vbus = 1'($urandom());
      wr(v); step();
      chk("R2 readback", rdata, exp_read(v, vbus));
      chk("R10 dma_en", {15'b0, dma_en}, {15'b0, v[9]});
      chk("R3 no fire", {14'b0, resume, susp}, 16'h0);
    end
    vbus = 1'b0; wr(16'h0000); step();

    // R3 repeated 1 writes do not fire
    wr(16'h0040); wr(16'h0040);
    for (int i = 0; i < 6; i++) tk();
    chk("R3 repeat one", {15'b0, resume}, 16'h0);
    wr(16'h0000);
    // R4 / R5 resume timing, second command mid-delay ignored
    tk(); tk();
    wr(16'h0040); wr(16'h0000);
    tk(); tk();
    chk("R4 before 5th", {15'b0, resume}, 16'h0);
    tk();
    chk("R5 rise on 5th", {15'b0, resume}, 16'h1);
    for (int i = 0; i < 9; i++) tk();
    chk("R4 high 9", {15'b0, resume}, 16'h1);
    tk();
    chk("R4 fall 10", {15'b0, resume}, 16'h0);

    // R6 / R8 suspend with clock stop
    wr(16'h0020); wr(16'h0000);
    chk("R6 suspended", {14'b0, susp, clk_en}, 16'h3);
    tk();
    chk("R6 one tick", {14'b0, susp, clk_en}, 16'h3);
    tk();
    chk("R6 stopped", {14'b0, susp, clk_en}, 16'h2);
    rd();
    chk("R8 no wake bit", {14'b0, susp, clk_en}, 16'h2);
    wr(16'h0004);
    chk("R8 still stopped", {14'b0, susp, clk_en}, 16'h2);
    rd();
    chk("R8 wake", {14'b0, susp, clk_en}, 16'h1);

    // R7 clock always on
    wr(16'h00A4); wr(16'h0084);
    for (int i = 0; i < 5; i++) tk();
    chk("R7 aon", {14'b0, susp, clk_en}, 16'h3);
    rd();
    chk("R7 wake", {14'b0, susp, clk_en}, 16'h1);

    // R9 soft reset aborts timers
    wr(16'h0060); wr(16'h0000);
    for (int i = 0; i < 5; i++) tk();
    chk("R9 pre resume", {14'b0, resume, susp}, 16'h3);
    wr(16'h0018); wr(16'h0000);
    chk("R9 pulse", {13'b0, srst, resume, susp}, 16'h4);
    chk("R9 cleared", rdata, 16'h0000);
    step();
    chk("R9 pulse end", {15'b0, srst}, 16'h0);
    for (int i = 0; i < 12; i++) tk();
    chk("R9 aborted", {14'b0, resume, susp}, 16'h0);

    // R11 level mode
    ilvl = 1'b1; step(); step();
    chk("R11 gie off", {15'b0, int_o}, 16'h0);
    wr(16'h0008);
    chk("R11 latency", {15'b0, int_o}, 16'h0);
    step();
    chk("R11 level on", {15'b0, int_o}, 16'h1);
    ilvl = 1'b0; step(); step();
    chk("R11 level off", {15'b0, int_o}, 16'h0);
    // pulse mode
    pmode = 1'b1; wr(16'h0000);
    ievt = 1'b1; step(); ievt = 1'b0; step();
    chk("R11 event lost", {15'b0, int_o}, 16'h0);
    wr(16'h0008);
    ievt = 1'b1; step(); ievt = 1'b0;
    chk("R11 event", {15'b0, int_o}, 16'h1);
    step();
    chk("R11 event end", {15'b0, int_o}, 16'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule